// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Target

This block is the target side of a two-wire serial EEPROM that keeps 8192 bytes in an on-chip register array. It synchronizes the clock and data lines and recognizes START, repeated START and STOP. It answers one 7-bit device address, made of a fixed family nibble and three strap inputs. The data line is driven only through an active-high pull-down enable, as an open-drain pad would be.

A host writes by sending the device address with the direction bit clear, a high and a low address byte, and then one or more data bytes. The bytes are held in a page buffer. They are written into the array only after STOP. A write cycle of programmable length then runs, and the target does not acknowledge its address until it ends. A write-protect input guards the upper quarter of the array. To read, the host loads the pointer with a write that carries no data, sends a repeated START and the address with the direction bit set, and then clocks bytes out for as long as it acknowledges them.

Top module: `eeprom_target`

## Requirements
- R1: The target acknowledges only the device byte whose upper seven bits are 1010 followed by strap_i[2:0]. Any other address gets no acknowledge and leaves the data line released.
- R2: After a write-direction device byte, the target takes a high address byte and then a low address byte. Only the low 13 bits of the pair are used, so the upper three bits of the high byte have no effect.
- R3: A single data byte that is acknowledged and followed by STOP is stored at the addressed location. A later read returns it.
- R4: In a page write, the low 6 pointer bits advance after each data byte and wrap from 63 to 0. The upper 7 bits stay fixed, so the bytes land inside one 64-byte page.
- R5: While wp_i is high at commit, locations 0x1800 to 0x1FFF keep their contents. Location 0x17FF and all lower ones stay writable. While wp_i is low, the whole array is writable.
- R6: After a committing STOP, the target leaves the data line released for WRITE_CYCLES clock cycles and refuses its own address during that time. Once the window ends, it acknowledges again.
- R7: A write ended by START or STOP before any complete data byte has been acknowledged starts no write cycle. The address is acknowledged again at once.
- R8: After a dummy write, a repeated START and the read-direction device byte, the target sends the byte at the pointer, most significant bit first. It sends the next byte after each host acknowledge. A host NACK makes it release the data line.
- R9: The read pointer advances by one after each byte sent and wraps from 0x1FFF to 0x0000.
- R10: sda_oe_o is low after reset. It is asserted only while the synchronized clock is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| strap_i | input | 3 | Low three bits of the device address |
| wp_i | input | 1 | Write protect for the upper quarter of the array |
| sda_oe_o | output | 1 | Pull-down enable for the data line (1 = drive low) |

## Verification
The assertions assume that the bus clock stays low for several system clocks after each falling edge. Under that assumption, a pull-down that rises one cycle after the falling edge is still inside the low phase. They also assume that the host changes the data line only while the clock is low, except when it forms START and STOP, so that no false condition is decoded. The bench host holds each bus phase for eight system clocks. It moves data only in the low phase, and it sends the next transaction only after its own wait has covered the shortened write cycle.

// File: rtl/eeprom_pkg.sv
package eeprom_pkg;

    localparam logic [3:0] DEV_FAMILY = 4'b1010;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEV,
        ST_ADDR_HI,
        ST_ADDR_LO,
        ST_WDATA,
        ST_RDATA
    } tgt_state_e;

    typedef struct packed {
        logic scl;
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_evt_t;

    function automatic logic dev_match(input logic [6:0] rx, input logic [2:0] strap);
        return rx == {DEV_FAMILY, strap};
    endfunction

    function automatic logic guarded_quarter(input logic [1:0] top_bits, input logic wp);
        return wp && (top_bits == 2'b11);
    endfunction

endpackage

// File: rtl/eeprom_bus_sampler.sv
module eeprom_bus_sampler
    import eeprom_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    output bus_evt_t evt_o
);
    logic [1:0] scl_sync;
    logic [1:0] sda_sync;
    logic       scl_q;
    logic       sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_sync <= 2'b11;
            sda_sync <= 2'b11;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            scl_sync <= {scl_sync[0], scl_i};
            sda_sync <= {sda_sync[0], sda_i};
            scl_q    <= scl_sync[1];
            sda_q    <= sda_sync[1];
        end
    end

    always_comb begin
        evt_o.scl      = scl_sync[1];
        evt_o.sda      = sda_sync[1];
        evt_o.scl_rise = scl_sync[1] & ~scl_q;
        evt_o.scl_fall = ~scl_sync[1] & scl_q;
        evt_o.start    = scl_sync[1] & scl_q & sda_q & ~sda_sync[1];
        evt_o.stop     = scl_sync[1] & scl_q & ~sda_q & sda_sync[1];
    end
endmodule

// File: rtl/eeprom_page_buffer.sv
module eeprom_page_buffer #(
    parameter  int PAGE_BYTES = 64,
    localparam int OFF_W      = $clog2(PAGE_BYTES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear_i,
    input  logic             load_i,
    input  logic [OFF_W-1:0] load_off_i,
    input  logic [7:0]       load_data_i,
    input  logic             commit_i,
    output logic             out_valid_o,
    output logic [OFF_W-1:0] out_off_o,
    output logic [7:0]       out_data_o
);
    logic [7:0]            data_q [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] valid_q;
    logic [OFF_W-1:0]      scan_q;
    logic                  active_q;

    always_ff @(posedge clk) begin
        if (load_i) data_q[load_off_i] <= load_data_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q  <= '0;
            scan_q   <= '0;
            active_q <= 1'b0;
        end else begin
            if (clear_i)     valid_q             <= '0;
            else if (load_i) valid_q[load_off_i] <= 1'b1;

            if (commit_i) begin
                active_q <= 1'b1;
                scan_q   <= '0;
            end else if (active_q) begin
                scan_q <= scan_q + 1'b1;
                if (scan_q == OFF_W'(PAGE_BYTES - 1)) active_q <= 1'b0;
            end
        end
    end

    assign out_valid_o = active_q & valid_q[scan_q];
    assign out_off_o   = scan_q;
    assign out_data_o  = data_q[scan_q];
endmodule

// File: rtl/eeprom_busy_timer.sv
module eeprom_busy_timer #(
    parameter  int WRITE_CYCLES = 250000,
    localparam int CW           = $clog2(WRITE_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    output logic busy_o
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)                cnt_q <= '0;
        else if (start_i)       cnt_q <= CW'(WRITE_CYCLES);
        else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end

    assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/eeprom_target.sv
module eeprom_target
    import eeprom_pkg::*;
#(
    parameter int ADDR_W       = 13,
    parameter int PAGE_BYTES   = 64,
    parameter int WRITE_CYCLES = 250000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [2:0] strap_i,
    input  logic       wp_i,
    output logic       sda_oe_o
);
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int OFF_W  = $clog2(PAGE_BYTES);
    localparam int PAGE_W = ADDR_W - OFF_W;
    localparam int HI_W   = ADDR_W - 8;

    bus_evt_t          evt;
    tgt_state_e        st_q;
    logic [3:0]        bit_q;
    logic [7:0]        sh_q;
    logic [7:0]        tx_q;
    logic [ADDR_W-1:0] ptr_q;
    logic [PAGE_W-1:0] page_q;
    logic              oe_q;
    logic              host_ack_q;
    logic              have_data_q;
    logic              busy;

    logic              buf_clear;
    logic              buf_load;
    logic              commit_go;
    logic              cm_valid;
    logic [OFF_W-1:0]  cm_off;
    logic [7:0]        cm_data;
    logic [ADDR_W-1:0] mem_waddr;
    logic              mem_we;

    logic [7:0] mem [DEPTH];

    eeprom_bus_sampler u_bus (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .evt_o (evt)
    );

    assign buf_clear = (st_q == ST_ADDR_LO) && evt.scl_fall && (bit_q == 4'd8) && !evt.start && !evt.stop;
    assign buf_load  = (st_q == ST_WDATA) && evt.scl_fall && (bit_q == 4'd8) && !evt.start && !evt.stop;
    assign commit_go = evt.stop && (st_q == ST_WDATA) && have_data_q;

    eeprom_page_buffer #(.PAGE_BYTES(PAGE_BYTES)) u_pbuf (
        .clk         (clk),
        .rst         (rst),
        .clear_i     (buf_clear),
        .load_i      (buf_load),
        .load_off_i  (ptr_q[OFF_W-1:0]),
        .load_data_i (sh_q),
        .commit_i    (commit_go),
        .out_valid_o (cm_valid),
        .out_off_o   (cm_off),
        .out_data_o  (cm_data)
    );

    eeprom_busy_timer #(.WRITE_CYCLES(WRITE_CYCLES)) u_busy (
        .clk     (clk),
        .rst     (rst),
        .start_i (commit_go),
        .busy_o  (busy)
    );

    // commit port: one buffered byte per cycle, top quarter gated by write protect
    assign mem_waddr = {page_q, cm_off};
    assign mem_we    = cm_valid && !guarded_quarter(mem_waddr[ADDR_W-1 -: 2], wp_i);

    always_ff @(posedge clk) begin
        if (mem_we) mem[mem_waddr] <= cm_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q        <= ST_IDLE;
            bit_q       <= '0;
            sh_q        <= '0;
            tx_q        <= '0;
            ptr_q       <= '0;
            page_q      <= '0;
            oe_q        <= 1'b0;
            host_ack_q  <= 1'b0;
            have_data_q <= 1'b0;
        end else begin
            if (commit_go) page_q <= ptr_q[ADDR_W-1:OFF_W];

            if (evt.start) begin
                st_q        <= ST_DEV;
                bit_q       <= '0;
                oe_q        <= 1'b0;
                have_data_q <= 1'b0;
            end else if (evt.stop) begin
                st_q        <= ST_IDLE;
                bit_q       <= '0;
                oe_q        <= 1'b0;
                have_data_q <= 1'b0;
            end else if (st_q == ST_RDATA) begin
                if (evt.scl_rise) begin
                    if (bit_q < 4'd8) begin
                        bit_q <= bit_q + 4'd1;
                    end else if (bit_q == 4'd8) begin
                        host_ack_q <= ~evt.sda;
                        bit_q      <= 4'd9;
                    end
                end else if (evt.scl_fall) begin
                    if (bit_q == 4'd9) begin
                        if (host_ack_q) begin
                            tx_q  <= mem[ptr_q];
                            oe_q  <= ~mem[ptr_q][7];
                            ptr_q <= ptr_q + 1'b1;
                            bit_q <= '0;
                        end else begin
                            st_q <= ST_IDLE;
                            oe_q <= 1'b0;
                        end
                    end else if (bit_q == 4'd8) begin
                        oe_q <= 1'b0;
                    end else if (bit_q != 4'd0) begin
                        oe_q <= ~tx_q[3'(4'd7 - bit_q)];
                    end
                end
            end else if (st_q != ST_IDLE) begin
                if (evt.scl_rise && bit_q < 4'd8) begin
                    sh_q  <= {sh_q[6:0], evt.sda};
                    bit_q <= bit_q + 4'd1;
                end else if (evt.scl_fall && bit_q == 4'd9) begin
                    oe_q  <= 1'b0;
                    bit_q <= '0;
                end else if (evt.scl_fall && bit_q == 4'd8) begin
                    bit_q <= 4'd9;
                    oe_q  <= 1'b1;
                    case (st_q)
                        ST_DEV: begin
                            if (dev_match(sh_q[7:1], strap_i) && !busy) begin
                                if (sh_q[0]) begin
                                    st_q       <= ST_RDATA;
                                    host_ack_q <= 1'b1;
                                end else begin
                                    st_q <= ST_ADDR_HI;
                                end
                            end else begin
                                st_q <= ST_IDLE;
                                oe_q <= 1'b0;
                            end
                        end
                        ST_ADDR_HI: begin
                            ptr_q[ADDR_W-1:8] <= sh_q[HI_W-1:0];
                            st_q              <= ST_ADDR_LO;
                        end
                        ST_ADDR_LO: begin
                            ptr_q[7:0] <= sh_q;
                            st_q       <= ST_WDATA;
                        end
                        ST_WDATA: begin
                            ptr_q[OFF_W-1:0] <= ptr_q[OFF_W-1:0] + 1'b1;
                            have_data_q      <= 1'b1;
                        end
                        default: ;
                    endcase
                end
            end
        end
    end

    assign sda_oe_o = oe_q;
endmodule

// File: rtl/eeprom_target_chk.sv
module eeprom_target_chk #(
    parameter int ADDR_W = 13,
    parameter int OFF_W  = 6
) (
    input logic              clk,
    input logic              rst,
    input logic              scl_s,
    input logic              sda_oe,
    input logic              busy,
    input logic              mem_we,
    input logic              start_det,
    input logic              stop_det,
    input logic              in_wdata,
    input logic              in_dev,
    input logic [3:0]        bit_cnt,
    input logic [ADDR_W-1:0] ptr
);
    // R10: pull-down only begins inside the clock low phase
    p_oe_scl_low_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> !scl_s);

    // R6: silent on the bus for the whole write window
    p_silent_busy_r6: assert property (@(posedge clk) disable iff (rst)
        busy |-> !sda_oe);

    // R3: the array changes only inside a write cycle
    p_we_in_busy_r3: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> busy);

    // R7: a write cycle is launched only by STOP
    p_busy_after_stop_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(stop_det));

    // R4: page bits of the pointer hold while data bytes arrive
    p_page_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (in_wdata && $past(in_wdata)) |-> (ptr[ADDR_W-1:OFF_W] == $past(ptr[ADDR_W-1:OFF_W])));

    // R8: any START, repeated or not, restarts device-byte reception
    p_start_restarts_r8: assert property (@(posedge clk) disable iff (rst)
        start_det |=> (in_dev && bit_cnt == 4'd0));
endmodule

bind eeprom_target eeprom_target_chk #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .scl_s     (evt.scl),
    .sda_oe    (sda_oe_o),
    .busy      (busy),
    .mem_we    (mem_we),
    .start_det (evt.start),
    .stop_det  (evt.stop),
    .in_wdata  (st_q == eeprom_pkg::ST_WDATA),
    .in_dev    (st_q == eeprom_pkg::ST_DEV),
    .bit_cnt   (bit_q),
    .ptr       (ptr_q)
);

// File: tb/tb_eeprom_target.sv
module tb_eeprom_target;
    localparam int CLK_PERIOD = 10;
    localparam int Q          = 8;
    localparam int WC         = 1000;
    localparam logic [7:0] DEV_WR = 8'hAA;
    localparam logic [7:0] DEV_RD = 8'hAB;

    typedef struct packed {
        logic [15:0] waddr;
        logic [7:0]  wdata;
        logic        wp;
        logic [15:0] raddr;
        logic [7:0]  exp;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{16'h0000, 8'h5A, 1'b0, 16'h0000, 8'h5A},
        '{16'h1FFF, 8'h3C, 1'b0, 16'h1FFF, 8'h3C},
        '{16'h1800, 8'h77, 1'b0, 16'h1800, 8'h77},
        '{16'h1800, 8'h99, 1'b1, 16'h1800, 8'h77},
        '{16'h17FF, 8'h42, 1'b1, 16'h17FF, 8'h42},
        '{16'hE123, 8'hA5, 1'b0, 16'h0123, 8'hA5}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl = 1'b1;
    logic       host_sda = 1'b1;
    logic       wp = 1'b0;
    logic       sda_oe;
    logic       sda_line;
    int         n_checks = 0;
    int         n_fail = 0;
    bit         done = 1'b0;

    assign sda_line = host_sda & ~sda_oe;

    always #(CLK_PERIOD/2) clk = ~clk;

    eeprom_target #(.WRITE_CYCLES(WC)) dut (
        .clk      (clk),
        .rst      (rst),
        .scl_i    (scl),
        .sda_i    (sda_line),
        .strap_i  (3'b101),
        .wp_i     (wp),
        .sda_oe_o (sda_oe)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wait_q();
        repeat (Q) @(negedge clk);
    endtask

    task automatic wait_h();
        repeat (Q/2) @(negedge clk);
    endtask

    task automatic bus_start();
        host_sda = 1'b1; scl = 1'b1; wait_q();
        host_sda = 1'b0; wait_q();
        scl = 1'b0; wait_q();
    endtask

    task automatic bus_restart();
        host_sda = 1'b1; wait_q();
        scl = 1'b1; wait_q();
        host_sda = 1'b0; wait_q();
        scl = 1'b0; wait_q();
    endtask

    task automatic bus_stop();
        host_sda = 1'b0; wait_q();
        scl = 1'b1; wait_q();
        host_sda = 1'b1; wait_q();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            host_sda = b[i]; wait_q();
            scl = 1'b1; wait_q();
            scl = 1'b0; wait_q();
        end
        host_sda = 1'b1; wait_q();
        scl = 1'b1; wait_h();
        ack = ~sda_line; wait_h();
        scl = 1'b0; wait_q();
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] b);
        host_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wait_q();
            scl = 1'b1; wait_h();
            b[i] = sda_line; wait_h();
            scl = 1'b0;
        end
        wait_h();
        host_sda = give_ack ? 1'b0 : 1'b1; wait_q();
        scl = 1'b1; wait_q();
        scl = 1'b0; wait_q();
        host_sda = 1'b1;
    endtask

    task automatic write_bytes(input logic [15:0] addr, input logic [7:0] d0,
                               input logic [7:0] d1, input logic [7:0] d2,
                               input logic [7:0] d3, input int n, output logic ack);
        logic a;
        bus_start();
        send_byte(DEV_WR, ack);
        send_byte(addr[15:8], a);
        send_byte(addr[7:0], a);
        if (n > 0) send_byte(d0, a);
        if (n > 1) send_byte(d1, a);
        if (n > 2) send_byte(d2, a);
        if (n > 3) send_byte(d3, a);
        bus_stop();
    endtask

    task automatic read_open(input logic [15:0] addr);
        logic a;
        bus_start();
        send_byte(DEV_WR, a);
        send_byte(addr[15:8], a);
        send_byte(addr[7:0], a);
        bus_restart();
        send_byte(DEV_RD, a);
    endtask

    task automatic wait_cycle();
        repeat (WC + 200) @(negedge clk);
    endtask

    initial begin
        repeat (500000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual hung expected finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic       ack;
        logic [7:0] b;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        chk("R10 reset release", {7'b0, sda_oe}, 8'h00);

        // table of single-byte writes, each read back
        for (int v = 0; v < NV; v++) begin
            wp = VECS[v].wp;
            write_bytes(VECS[v].waddr, VECS[v].wdata, 8'h00, 8'h00, 8'h00, 1, ack);
            chk("R1 own address ack", {7'b0, ack}, 8'h01);
            wait_cycle();
            wp = 1'b0;
            read_open(VECS[v].raddr);
            recv_byte(1'b0, b);
            bus_stop();
            chk("R3 R5 R2 vector readback", b, VECS[v].exp);
        end

        // R1: foreign addresses are ignored
        bus_start(); send_byte(8'hA8, ack); bus_stop();
        chk("R1 wrong strap nack", {7'b0, ack}, 8'h00);
        bus_start(); send_byte(8'h2A, ack); bus_stop();
        chk("R1 wrong family nack", {7'b0, ack}, 8'h00);

        // R4 R8: page write then sequential read
        write_bytes(16'h0040, 8'h10, 8'h11, 8'h12, 8'h13, 4, ack);
        wait_cycle();
        read_open(16'h0040);
        recv_byte(1'b1, b); chk("R8 seq byte 0", b, 8'h10);
        recv_byte(1'b1, b); chk("R8 seq byte 1", b, 8'h11);
        recv_byte(1'b1, b); chk("R8 seq byte 2", b, 8'h12);
        recv_byte(1'b0, b); chk("R8 seq byte 3", b, 8'h13);
        chk("R8 released after nack", {7'b0, sda_oe}, 8'h00);
        bus_stop();

        // R4: wrap inside the page
        write_bytes(16'h007E, 8'hE0, 8'hE1, 8'hE2, 8'h00, 3, ack);
        wait_cycle();
        read_open(16'h007E);
        recv_byte(1'b1, b); chk("R4 page end-1", b, 8'hE0);
        recv_byte(1'b0, b); chk("R4 page end", b, 8'hE1);
        bus_stop();
        read_open(16'h0040);
        recv_byte(1'b1, b); chk("R4 wrapped to page start", b, 8'hE2);
        recv_byte(1'b0, b); chk("R4 next untouched", b, 8'h11);
        bus_stop();

        // R6: busy window
        write_bytes(16'h0200, 8'h66, 8'h00, 8'h00, 8'h00, 1, ack);
        bus_start(); send_byte(DEV_WR, ack); bus_stop();
        chk("R6 nack while busy", {7'b0, ack}, 8'h00);
        wait_cycle();
        bus_start(); send_byte(DEV_WR, ack); bus_stop();
        chk("R6 ack after window", {7'b0, ack}, 8'h01);

        // R7: abort with no data starts no cycle
        write_bytes(16'h0200, 8'h00, 8'h00, 8'h00, 8'h00, 0, ack);
        bus_start(); send_byte(DEV_WR, ack); bus_stop();
        chk("R7 ack right after abort", {7'b0, ack}, 8'h01);
        read_open(16'h0200);
        recv_byte(1'b0, b);
        bus_stop();
        chk("R7 data kept", b, 8'h66);

        // R9: read pointer wraps at the array end
        read_open(16'h1FFF);
        recv_byte(1'b1, b); chk("R9 last location", b, 8'h3C);
        recv_byte(1'b0, b); chk("R9 wrapped to zero", b, 8'h5A);
        bus_stop();

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule